// File: doc/BRIEF.md
# Millisecond Interval Timer with Level Interrupt

This block generates a periodic interrupt whose period is programmed in whole milliseconds. Software writes a 9-bit reload value `r`, which gives a period of `r+1` milliseconds. A prescaler divides the core clock down to one-millisecond steps, using a parameter that gives the number of clock cycles in one millisecond. A period counter counts those steps. When a period ends, the interrupt line goes high and the next period starts in the same cycle, so the timer does not drift. The interrupt is a level and stays high until software acknowledges it.

Software drives the block through two strobes. A reload write sets the period, lowers the interrupt and restarts timing from zero. A count read returns zero and acknowledges the interrupt. The interrupt line comes from a two-state controller:

- `ST_QUIET`: the interrupt is low.
- `ST_FIRED`: the interrupt is high.

The controller has these transitions:

- `T_EXPIRE` moves from QUIET to FIRED when a period ends.
- `T_REARM` keeps FIRED in FIRED when a period ends.
- `T_ACK` moves from FIRED to QUIET on a count read.
- `T_RELOAD` moves from either state to QUIET on a reload write.
- `T_HOLD` keeps the current state when none of the above applies.

When two events fall in the same cycle, a reload write wins over an expiry, and an expiry wins over an acknowledge.

Top module: `interval_timer`

## Requirements
- R1: A reload write keeps only bits [8:0] of `reload_wdata` and discards the higher bits. For example, writing 0xFFFFFE05 gives a 6 ms period.
- R2: The interval from a reload write, or from a period end, to the next rise of `tick_irq` is exactly (r+1)*CYC_PER_MS clock cycles. It is counted from the clock edge that samples the write.
- R3: A reload write lowers `tick_irq` at the sampling edge and restarts timing. This also holds when a period ends in that same cycle.
- R4: A period end raises `tick_irq` at the next edge. The following period begins at once, with no idle cycles, so consecutive rises are exactly (r+1)*CYC_PER_MS cycles apart.
- R5: `tick_irq` stays high until it is acknowledged or a reload is written. It stays high across further period ends that are not acknowledged.
- R6: While `count_re` is high, `count_rdata` reads zero. A count read lowers `tick_irq` at the sampling edge.
- R7: If a count read and a period end fall in the same cycle, `tick_irq` is high after that edge.
- R8: After reset, the reload value is 0 and `tick_irq` is low. The first rise comes CYC_PER_MS cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | 32 | Write data; only bits [8:0] are kept |
| count_re | input | 1 | Count register read strobe (acknowledge) |
| count_rdata | output | 32 | Count read data, always zero |
| tick_irq | output | 1 | Level interrupt |

## Verification
The bench runs with three clock cycles per millisecond and sweeps the reload values 0 to 24 and 505 to 511. For each value it measures the interval from the write to the first rise and then the rise-to-rise interval, which separates an off-by-one in the prescaler from one in the period counter. A write with the high bits set separates truncation from a wider comparison. Strobes placed exactly on a period end test the priority order: a reload on an expiry, and a read on an expiry. A run with no acknowledge tells a level output apart from a pulse output.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_FIRED = 1'b1
    } itmr_state_e;
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int CYC_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ms_tick
);
    localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);

    logic [PW-1:0] psc_q;

    assign ms_tick = (psc_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (restart || ms_tick) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + 1'b1;
        end
    end
endmodule

// File: rtl/itmr_period_cnt.sv
module itmr_period_cnt #(
    parameter int RELOAD_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RELOAD_W-1:0] load_val,
    input  logic                ms_tick,
    output logic                expire
);
    logic [RELOAD_W-1:0] reload_q;
    logic [RELOAD_W-1:0] elapsed_q;
    logic                at_end;

    assign at_end = (elapsed_q == reload_q);
    assign expire = ms_tick && at_end && !load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (load) begin
            reload_q <= load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (load) begin
            elapsed_q <= '0;
        end else if (ms_tick) begin
            elapsed_q <= at_end ? '0 : elapsed_q + 1'b1;
        end
    end
endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
    import itmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reload_we,
    input  logic count_re,
    input  logic expire,
    output logic irq
);
    itmr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (reload_we) begin
                    state_d = ST_QUIET;          // T_RELOAD
                end else if (expire) begin
                    state_d = ST_FIRED;          // T_EXPIRE
                end
            end
            ST_FIRED: begin
                if (reload_we) begin
                    state_d = ST_QUIET;          // T_RELOAD
                end else if (expire) begin
                    state_d = ST_FIRED;          // T_REARM
                end else if (count_re) begin
                    state_d = ST_QUIET;          // T_ACK
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == ST_FIRED);
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CYC_PER_MS = 50000,
    parameter int RELOAD_W   = 9,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_we,
    input  logic [DATA_W-1:0] reload_wdata,
    input  logic              count_re,
    output logic [DATA_W-1:0] count_rdata,
    output logic              tick_irq
);
    logic ms_tick;
    logic expire;

    assign count_rdata = '0;

    itmr_prescaler #(.CYC_PER_MS(CYC_PER_MS)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (reload_we),
        .ms_tick (ms_tick)
    );

    itmr_period_cnt #(.RELOAD_W(RELOAD_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload_we),
        .load_val (reload_wdata[RELOAD_W-1:0]),
        .ms_tick  (ms_tick),
        .expire   (expire)
    );

    itmr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_we (reload_we),
        .count_re  (count_re),
        .expire    (expire),
        .irq       (tick_irq)
    );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reload_we,
    input logic              count_re,
    input logic [DATA_W-1:0] count_rdata,
    input logic              tick_irq,
    input logic              expire
);
    a_r3_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reload_we |=> !tick_irq);

    a_r4_expiry_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !reload_we) |=> tick_irq);

    a_r5_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_irq && !count_re && !reload_we) |=> tick_irq);

    a_r6_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        count_re |-> (count_rdata == '0));

    a_r6_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (count_re && !expire && !reload_we) |=> !tick_irq);

    a_r2_rise_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_irq) |-> $past(expire));

    a_r7_expiry_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && count_re && !reload_we) |=> tick_irq);
endmodule

bind interval_timer interval_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reload_we   (reload_we),
    .count_re    (count_re),
    .count_rdata (count_rdata),
    .tick_irq    (tick_irq),
    .expire      (expire)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
    localparam int CYC = 3;
    localparam int LIMIT = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reload_we = 1'b0;
    logic [31:0] reload_wdata = '0;
    logic        count_re = 1'b0;
    logic [31:0] count_rdata;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    interval_timer #(.CYC_PER_MS(CYC)) u_interval_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_we    (reload_we),
        .reload_wdata (reload_wdata),
        .count_re     (count_re),
        .count_rdata  (count_rdata),
        .tick_irq     (tick_irq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reload(input logic [31:0] v);
        reload_we = 1'b1;
        reload_wdata = v;
        step();
        reload_we = 1'b0;
    endtask

    task automatic ack();
        count_re = 1'b1;
        step();
        count_re = 1'b0;
    endtask

    task automatic edges_to_rise(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!tick_irq && n < LIMIT);
    endtask

    initial begin
        int n;
        #1;
        check("R8 irq low in reset", tick_irq, 0);
        repeat (3) step();
        rst_n = 1'b1;
        check("R8 irq low after reset", tick_irq, 0);
        edges_to_rise(n);
        check("R8 first rise after one ms", n, CYC);
        ack();
        check("R6 ack lowers irq", tick_irq, 0);

        // R2/R4 sweep over reload values
        for (int r = 0; r < 25; r++) begin
            write_reload(32'(r));
            check("R3 irq low after write", tick_irq, 0);
            edges_to_rise(n);
            check("R2 write to rise", n, (r + 1) * CYC);
            ack();
            edges_to_rise(n);
            check("R4 rise to rise", n + 1, (r + 1) * CYC);
            ack();
        end
        for (int r = 505; r < 512; r++) begin
            write_reload(32'(r));
            edges_to_rise(n);
            check("R2 write to rise high reload", n, (r + 1) * CYC);
            ack();
            edges_to_rise(n);
            check("R4 rise to rise high reload", n + 1, (r + 1) * CYC);
            ack();
        end

        // R1 truncation
        write_reload(32'hFFFF_FE05);
        edges_to_rise(n);
        check("R1 high bits discarded", n, 6 * CYC);

        // R5 held without ack across a further expiry
        for (int k = 0; k < 6 * CYC; k++) begin
            step();
            check("R5 irq held", tick_irq, 1);
        end

        // R6 read data and ack
        count_re = 1'b1;
        #1;
        check("R6 read data zero", count_rdata, 0);
        step();
        count_re = 1'b0;
        check("R6 read lowers irq", tick_irq, 0);

        // R7 read coincident with expiry
        write_reload(32'd1);
        for (int k = 0; k < 2 * CYC - 1; k++) step();
        check("R7 irq low before expiry", tick_irq, 0);
        count_re = 1'b1;
        step();
        count_re = 1'b0;
        check("R7 expiry beats ack", tick_irq, 1);
        ack();

        // R3 reload coincident with expiry
        write_reload(32'd2);
        for (int k = 0; k < 3 * CYC - 1; k++) step();
        write_reload(32'd0);
        check("R3 reload beats expiry", tick_irq, 0);
        edges_to_rise(n);
        check("R3 restart after coincident write", n, CYC);

        // R3 reload lowers a raised irq
        write_reload(32'd4);
        check("R3 reload clears raised irq", tick_irq, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule